// File: doc/BRIEF.md
# Asynchronous Processor Register Bus Slave

This block gives an external processor read and write access to a bank of 32-bit registers over an asynchronous parallel bus. The bus has an active-low select, separate active-low read and write strobes, an 11-bit address and a 32-bit data path. The data path is split into input, output and output-enable pins so that the pad ring can build the bidirectional pin. The processor ends every access by waiting for an active-low ready. There are no fixed wait states.

All bus inputs are resynchronised into the local clock domain, and the synchronised strobes are edge-detected. A write takes its address when the write strobe falls and its data when the strobe rises. A read takes its address when the read strobe falls. The block fetches the word, drives it, and only then lowers ready. Ready returns high once the active strobe has been released. The select may stay low across back-to-back accesses, provided both strobes go high between them. Addresses beyond the implemented bank discard writes and read as zero.

Top module: `cpu_bus_slave`

## Requirements
- R1: After reset, ready is high, the data output enable is low and every implemented register reads 0.
- R2: A strobe that falls while the select is high starts no access: ready stays high and no register changes.
- R3: On a write, the address present when the write strobe falls selects the register. The data present when the strobe rises is the value stored. Changes of the address bus after the fall have no effect.
- R4: On a read, the address present when the read strobe falls selects the register. The addressed value is on the data output when ready goes low.
- R5: Ready goes low only inside an access and stays low while the strobe is held low. It returns high within SYNC_STAGES+3 clock cycles after the strobe is released.
- R6: The data output enable is high only while the synchronised select and read strobe are both low. It is low during writes and after a read's strobe is released.
- R7: With the select held low, consecutive accesses separated only by strobe releases each complete correctly.
- R8: Implemented registers sit at addresses 0 to NUM_REGS-1 (16 by default). A write to any higher address is discarded, and a read from one returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel_n | input | 1 | Processor select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 11 | Register address |
| bus_din | input | 32 | Write data from the processor |
| bus_dout | output | 32 | Read data to the processor |
| bus_doe | output | 1 | Output enable for the data pins |
| bus_rdy_n | output | 1 | Access complete, active low |

## Verification
The assertions assume that the processor never lowers both strobes at once. They also assume that address and data are steady for at least SYNC_STAGES clock cycles around each strobe edge, because the multi-bit buses are synchronised flop by flop. The bench changes every input only at falling clock edges and sets address and data together with, or before, the strobe. Where it changes a bus in the middle of an access, it waits several cycles before releasing the strobe. Each access waits for ready before the strobe is released.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_RD_FETCH = 2'd1,
      ST_RD_ACK   = 2'd2,
      ST_WR_ACK   = 2'd3
   } cbs_state_e;
endpackage

// File: rtl/cbs_sync.sv
module cbs_sync #(
   parameter int              WIDTH   = 1,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("cbs_sync: WIDTH must be at least 1");
      end
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
            end else begin
               stage_q[0] <= d;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cbs_regfile.sv
module cbs_regfile #(
   parameter int              ADDR_W   = 11,
   parameter int              DATA_W   = 32,
   parameter int              NUM_REGS = 16,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rf_addr,
   input  logic              rf_we,
   input  logic [DATA_W-1:0] rf_wdata,
   output logic [DATA_W-1:0] rf_rdata
);
   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   generate
      if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_depth
         $error("cbs_regfile: NUM_REGS out of range for ADDR_W");
      end
   endgenerate

   logic              hit;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] reg_q [NUM_REGS];

   assign hit = (32'(rf_addr) < NUM_REGS);
   assign idx = IDX_W'(rf_addr);

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             reg_q[g] <= RST_VAL;
            else if (rf_we && hit && idx == IDX_W'(g)) reg_q[g] <= rf_wdata;
         end
      end
   endgenerate

   always_comb begin
      rf_rdata = '0;
      if (hit) rf_rdata = reg_q[idx];
   end

   AST_UNIMPL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(rf_addr) >= NUM_REGS) |-> (rf_rdata == '0)); // R8
endmodule

// File: rtl/cbs_ctrl.sv
module cbs_ctrl
   import cbs_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_sel_n,
   input  logic              s_rd_n,
   input  logic              s_wr_n,
   input  logic [ADDR_W-1:0] s_addr,
   input  logic [DATA_W-1:0] s_din,
   output logic [ADDR_W-1:0] rf_addr,
   output logic              rf_we,
   output logic [DATA_W-1:0] rf_wdata,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic [DATA_W-1:0] dout,
   output logic              doe,
   output logic              rdy_n
);
   cbs_state_e        state_q, state_d;
   logic              rd_prev_q, wr_prev_q;
   logic              rd_fall, wr_fall;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] dout_q;

   assign rd_fall = rd_prev_q & ~s_rd_n;
   assign wr_fall = wr_prev_q & ~s_wr_n;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (!s_sel_n && rd_fall)      state_d = ST_RD_FETCH;
            else if (!s_sel_n && wr_fall) state_d = ST_WR_ACK;
         end
         ST_RD_FETCH: state_d = ST_RD_ACK;
         ST_RD_ACK:   if (s_rd_n) state_d = ST_IDLE;
         ST_WR_ACK:   if (s_wr_n) state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         rd_prev_q <= 1'b1;
         wr_prev_q <= 1'b1;
         addr_q    <= '0;
         dout_q    <= '0;
      end else begin
         state_q   <= state_d;
         rd_prev_q <= s_rd_n;
         wr_prev_q <= s_wr_n;
         if (state_q == ST_IDLE && !s_sel_n && (rd_fall || wr_fall))
            addr_q <= s_addr;
         if (state_q == ST_RD_FETCH)
            dout_q <= rf_rdata;
      end
   end

   assign rf_addr  = addr_q;
   assign rf_we    = (state_q == ST_WR_ACK) && s_wr_n && !s_sel_n;
   assign rf_wdata = s_din;
   assign dout     = dout_q;
   assign doe      = ~s_sel_n & ~s_rd_n;
   assign rdy_n    = !((state_q == ST_RD_ACK) || (state_q == ST_WR_ACK));

   AST_COMMIT_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $past(!s_sel_n && !s_wr_n)); // R2
   AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we); // R3
   AST_DATA_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rdy_n) && !s_rd_n) |-> $stable(rf_addr)); // R4
   AST_READY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && s_rd_n && s_wr_n) |=> rdy_n); // R5
   AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n && !s_rd_n) |=> !rdy_n); // R5
   AST_NO_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WR_ACK) |-> !doe); // R6
endmodule

// File: rtl/cpu_bus_slave.sv
module cpu_bus_slave #(
   parameter int ADDR_W      = 11,
   parameter int DATA_W      = 32,
   parameter int NUM_REGS    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel_n,
   input  logic              bus_rd_n,
   input  logic              bus_wr_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   output logic              bus_rdy_n
);
   localparam int CTL_W = 3;
   localparam int BUS_W = ADDR_W + DATA_W;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("cpu_bus_slave: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic [CTL_W-1:0]  ctl_s;
   logic [BUS_W-1:0]  bus_s;
   logic [ADDR_W-1:0] rf_addr;
   logic              rf_we;
   logic [DATA_W-1:0] rf_wdata, rf_rdata;

   cbs_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_ctl (
      .clk(clk), .rst_n(rst_n),
      .d({bus_sel_n, bus_rd_n, bus_wr_n}), .q(ctl_s));

   cbs_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
      .clk(clk), .rst_n(rst_n),
      .d({bus_addr, bus_din}), .q(bus_s));

   cbs_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .s_sel_n(ctl_s[2]), .s_rd_n(ctl_s[1]), .s_wr_n(ctl_s[0]),
      .s_addr(bus_s[BUS_W-1:DATA_W]), .s_din(bus_s[DATA_W-1:0]),
      .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
      .dout(bus_dout), .doe(bus_doe), .rdy_n(bus_rdy_n));

   cbs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata));

   AST_READY_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_rdy_n) |-> $past(!ctl_s[2])); // R2
endmodule

// File: tb/cpu_bus_slave_tb.sv
module cpu_bus_slave_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 11;
   localparam int DATA_W = 32;
   localparam int NUM_REGS = 16;
   localparam int SYNC_STAGES = 2;
   localparam int NVEC = 8;
   localparam int WAIT_MAX = 64;
   localparam int WDOG_MAX = 50000;
   localparam logic [ADDR_W-1:0] VEC_ADDR [NVEC] = '{11'd0, 11'd1, 11'd7, 11'd15,
                                                      11'd16, 11'd2047, 11'd5, 11'd10};
   localparam logic [DATA_W-1:0] VEC_DATA [NVEC] = '{32'h1111_0000, 32'hDEAD_BEEF, 32'h0000_0007,
                                                      32'hFFFF_FFFF, 32'hABCD_1234, 32'h5A5A_A5A5,
                                                      32'h8000_0001, 32'h0BAD_F00D};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_din = '0;
   logic [DATA_W-1:0] bus_dout;
   logic bus_doe, bus_rdy_n;
   int n_chk = 0, n_bad = 0, cyc = 0;
   logic [DATA_W-1:0] rd_val;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_bus_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
                   .SYNC_STAGES(SYNC_STAGES)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n),
      .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_din(bus_din),
      .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rdy_n(bus_rdy_n));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WDOG_MAX) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected <= %0d", cyc, WDOG_MAX);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_rdy(input logic lvl, output int waited);
      waited = 0;
      while (bus_rdy_n !== lvl && waited < WAIT_MAX) begin
         @(negedge clk); waited++;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
      int w;
      @(negedge clk);
      bus_sel_n = 1'b0; bus_addr = a; bus_din = d; bus_wr_n = 1'b0;
      wait_rdy(1'b0, w);
      chk("R6 no drive in write", 32'(bus_doe), 32'd0);
      bus_wr_n = 1'b1;
      wait_rdy(1'b1, w);
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
      int w;
      @(negedge clk);
      bus_sel_n = 1'b0; bus_addr = a; bus_rd_n = 1'b0;
      wait_rdy(1'b0, w);
      d = bus_dout;
      chk("R6 drive during read", 32'(bus_doe), 32'd1);
      bus_rd_n = 1'b1;
      wait_rdy(1'b1, w);
      chk("R5 release latency", 32'(w <= SYNC_STAGES + 3), 32'd1);
      chk("R6 released after read", 32'(bus_doe), 32'd0);
   endtask

   task automatic deselect();
      @(negedge clk); bus_sel_n = 1'b1; idle(3);
   endtask

   initial begin
      int w;
      logic [DATA_W-1:0] exp_tab [NVEC];
      idle(3);
      chk("R1 ready after reset", 32'(bus_rdy_n), 32'd1);
      chk("R1 doe after reset", 32'(bus_doe), 32'd0);
      rst_n = 1'b1;
      idle(3);
      bus_read(11'd3, rd_val);
      chk("R1 register reset value", rd_val, 32'd0);
      deselect();

      for (int i = 0; i < NVEC; i++) begin
         bus_write(VEC_ADDR[i], VEC_DATA[i]);
         deselect();
         exp_tab[i] = (32'(VEC_ADDR[i]) < NUM_REGS) ? VEC_DATA[i] : '0;
      end
      for (int i = 0; i < NVEC; i++) begin
         bus_read(VEC_ADDR[i], rd_val);
         chk((32'(VEC_ADDR[i]) < NUM_REGS) ? "R4 table read" : "R8 unimplemented read",
             rd_val, exp_tab[i]);
         deselect();
      end

      // R2: a strobe asserted while the select is high is ignored
      @(negedge clk);
      bus_addr = 11'd1; bus_din = 32'h0000_BAD0; bus_wr_n = 1'b0;
      idle(10);
      chk("R2 no ready without select", 32'(bus_rdy_n), 32'd1);
      bus_wr_n = 1'b1; idle(4);
      @(negedge clk); bus_rd_n = 1'b0; idle(10);
      chk("R2 no read without select", 32'(bus_rdy_n), 32'd1);
      chk("R2 no drive without select", 32'(bus_doe), 32'd0);
      bus_rd_n = 1'b1; idle(4);
      bus_read(11'd1, rd_val);
      chk("R2 register unchanged", rd_val, 32'hDEAD_BEEF);
      deselect();

      // R3: address from the falling edge, data from the rising edge
      @(negedge clk);
      bus_sel_n = 1'b0; bus_addr = 11'd4; bus_din = 32'h1234_0000; bus_wr_n = 1'b0;
      wait_rdy(1'b0, w);
      bus_addr = 11'd6; bus_din = 32'h4444_6666;
      idle(5);
      chk("R5 ready held while strobe low", 32'(bus_rdy_n), 32'd0);
      bus_wr_n = 1'b1;
      wait_rdy(1'b1, w);
      deselect();
      bus_read(11'd4, rd_val);
      chk("R3 data at rising edge", rd_val, 32'h4444_6666);
      deselect();
      bus_read(11'd6, rd_val);
      chk("R3 late address ignored", rd_val, 32'd0);
      deselect();

      // R4: read address taken at the falling edge
      @(negedge clk);
      bus_sel_n = 1'b0; bus_addr = 11'd7; bus_rd_n = 1'b0;
      idle(SYNC_STAGES + 1);
      bus_addr = 11'd0;
      wait_rdy(1'b0, w);
      chk("R4 address at falling edge", bus_dout, 32'h0000_0007);
      bus_rd_n = 1'b1;
      wait_rdy(1'b1, w);
      deselect();

      // R7: select held low across back-to-back accesses
      bus_write(11'd8, 32'hCAFE_0008);
      bus_write(11'd9, 32'hCAFE_0009);
      bus_write(11'd300, 32'hCAFE_0300);
      bus_read(11'd8, rd_val);
      chk("R7 back-to-back first", rd_val, 32'hCAFE_0008);
      bus_read(11'd9, rd_val);
      chk("R7 back-to-back second", rd_val, 32'hCAFE_0009);
      bus_read(11'd300, rd_val);
      chk("R8 discarded write reads zero", rd_val, 32'd0);
      deselect();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule